// File: doc/BRIEF.md
# Auto-Ranging Clock Frequency Meter Sequencer

This block drives an external gated edge counter to measure the frequency of one of up to 128 internal clock sources. On a start pulse it captures the source index and programs the counter with the longest gate window, 640 µs. If the returned count is saturated, it reprograms the counter with a window 32 µs shorter and tries again. The first count that is not saturated ends the search. That count is then scaled to Hz with round-to-nearest, and a precision figure is derived from the gate that was accepted.

Each attempt uses the counter's control register through a simple write strobe and data word. Completion is detected by polling the counter's busy flag at a fixed interval, and a timeout ends the request if busy never clears. Both divisions run on one shared sequential restoring divider. The caller sees a one-cycle done pulse together with the frequency, the precision and an error code.

Top module: `fms_autorange`

## Requirements
- R1: The first attempt of a request uses a gate of 640 µs. Each retry uses a gate 32 µs shorter than the previous one, and no gate below 32 µs is ever programmed.
- R2: A retry happens only when the count read back equals the saturated value 16'hFFFF. Any other count ends the search and gives err_o = 2'b00.
- R3: Every attempt issues exactly four control writes, in consecutive cycles except the last. The word layout is: bits [15:0] hold gate−1, bit 16 is enable, bit 17 is run, bits [24:18] hold the source index, and bits [31:25] are zero. The writes are, in order: an all-zero word; the gate and source with enable and run low; the same fields with enable and run high; after busy clears, the same fields with run high and enable low. The count is read (cnt_re_o high) in the cycle after the last write.
- R4: Busy is sampled once every POLL_US·CLKS_PER_US cycles after the arming write. The disable write comes one cycle after the first sample that sees busy low. If TIMEOUT_US/POLL_US samples all see busy high, done_o rises one cycle after the last sample with err_o = 2'b01 and both results zero.
- R5: On success freq_o = (count·1,000,000 + gate/2) / gate, an integer division. This is the frequency in Hz rounded to nearest.
- R6: On success prec_o = 2,000,000 / gate, truncated, for the accepted gate.
- R7: If the count is saturated at the 32 µs gate too, the request ends with err_o = 2'b10 and freq_o = prec_o = 0.
- R8: done_o is a single-cycle pulse. freq_o, prec_o and err_o are valid in that cycle and keep their values until the next accepted start.
- R9: A start pulse that arrives while a request is in progress is ignored. The running request keeps its source and its results, and no extra done pulse appears.
- R10: After reset, done_o, err_o, freq_o, prec_o, cfg_we_o and cnt_re_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| src_i | input | SRC_W (7) | Source index captured with the start pulse |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 00 none, 01 timeout, 10 overflow |
| freq_o | output | OUT_W (32) | Measured frequency in Hz |
| prec_o | output | OUT_W (32) | Precision in Hz |
| cfg_we_o | output | 1 | Counter control write strobe |
| cfg_word_o | output | CFG_W (32) | Counter control word |
| meas_busy_i | input | 1 | Counter busy flag |
| cnt_re_o | output | 1 | Count read strobe; cnt_val_i is sampled in this cycle |
| cnt_val_i | input | CNT_W (16) | Count from the counter |

## Verification
The first three control writes appear in the three cycles after the start is taken. The disable write comes exactly k·P+1 cycles after the arming write, where P is the poll period and k is the first poll that finds busy low. The bench's counter model holds busy for G cycles, so k = G/P+1, and the bench compares the measured distance with that value for every attempt. A timeout ends with done exactly N·P+1 cycles after the arming write, where N is the poll limit. Results follow the last read after two divider passes of about 38 cycles each, so the bench waits for the done pulse with a bound and compares freq_o, prec_o and err_o in the cycle it is high. It checks the pulse width and that the values are still held on the following cycles.

// File: rtl/fms_pkg.sv
`timescale 1ns/1ps
package fms_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_PROG, ST_ARM, ST_WAIT, ST_DIS,
    ST_READ, ST_EVAL, ST_DIVF, ST_DIVP, ST_FIN
  } fms_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'b00,
    ERR_TIMEOUT  = 2'b01,
    ERR_OVERFLOW = 2'b10
  } fms_err_e;
endpackage

// File: rtl/fms_divider.sv
`timescale 1ns/1ps
module fms_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W:0]   rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  logic [DEN_W:0]   rem_sh;
  logic             ge;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    ge     = (rem_sh >= {1'b0, den_q});
  end

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i) begin
      quo_d  = num_i;
      rem_d  = '0;
      den_d  = den_i;
      cnt_d  = CNT_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo_d = {quo_q[NUM_W-2:0], ge};
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/fms_poll_timer.sv
`timescale 1ns/1ps
module fms_poll_timer #(
  parameter int PERIOD = 2000,
  parameter int COUNT  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);
  localparam int TW = $clog2(PERIOD + 1);
  localparam int PW = $clog2(COUNT + 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  assign tick_o = run_i && (tcnt_q == TW'(PERIOD - 1));
  assign last_o = (pcnt_q == PW'(COUNT - 1));

  always_comb begin
    tcnt_d = tcnt_q;
    pcnt_d = pcnt_q;
    if (clr_i) begin
      tcnt_d = '0;
      pcnt_d = '0;
    end else if (run_i) begin
      if (tick_o) begin
        tcnt_d = '0;
        pcnt_d = pcnt_q + PW'(1);
      end else begin
        tcnt_d = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/fms_autorange.sv
`timescale 1ns/1ps
module fms_autorange
  import fms_pkg::*;
#(
  parameter int CLKS_PER_US = 200,
  parameter int POLL_US     = 10,
  parameter int TIMEOUT_US  = 10000,
  parameter int GATE_MAX    = 640,
  parameter int GATE_STEP   = 32,
  parameter int GATE_MIN    = 32,
  parameter int CNT_W       = 16,
  parameter int SRC_W       = 7,
  parameter int OUT_W       = 32,
  parameter int GDIV_W      = 16,
  parameter int CFG_W       = 32,
  parameter int SCALE       = 1000000,
  parameter int PREC_NUM    = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [OUT_W-1:0]  freq_o,
  output logic [OUT_W-1:0]  prec_o,
  output logic              cfg_we_o,
  output logic [CFG_W-1:0]  cfg_word_o,
  input  logic              meas_busy_i,
  output logic              cnt_re_o,
  input  logic [CNT_W-1:0]  cnt_val_i
);
  localparam int POLL_CYC  = POLL_US * CLKS_PER_US;
  localparam int MAX_POLLS = TIMEOUT_US / POLL_US;
  localparam int GATE_W    = $clog2(GATE_MAX + 1);
  localparam int NUM_W     = CNT_W + $clog2(SCALE) + 1;
  localparam int EN_BIT    = GDIV_W;
  localparam int RUN_BIT   = GDIV_W + 1;
  localparam int SRC_LSB   = GDIV_W + 2;
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  fms_state_e        state_q, state_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [GATE_W-1:0] gate_q, gate_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OUT_W-1:0]  freq_q, freq_d;
  logic [OUT_W-1:0]  prec_q, prec_d;
  logic [1:0]        err_q, err_d;

  logic              div_start, div_done;
  logic [NUM_W-1:0]  div_num, div_quo;
  logic [OUT_W-1:0]  div_res;
  logic              tmr_tick, tmr_last;
  logic [CFG_W-1:0]  prog_word;

  fms_divider #(.NUM_W(NUM_W), .DEN_W(GATE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (gate_q),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  fms_poll_timer #(.PERIOD(POLL_CYC), .COUNT(MAX_POLLS)) u_poll (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clr_i  (state_q == ST_ARM),
    .run_i  (state_q == ST_WAIT),
    .tick_o (tmr_tick),
    .last_o (tmr_last)
  );

  // quotient saturated into the output width
  assign div_res = (|div_quo[NUM_W-1:OUT_W]) ? {OUT_W{1'b1}} : div_quo[OUT_W-1:0];

  always_comb begin
    prog_word                     = '0;
    prog_word[GDIV_W-1:0]         = GDIV_W'(gate_q - GATE_W'(1));
    prog_word[SRC_LSB +: SRC_W]   = src_q;
  end

  always_comb begin
    state_d    = state_q;
    src_d      = src_q;
    gate_d     = gate_q;
    cnt_d      = cnt_q;
    freq_d     = freq_q;
    prec_d     = prec_q;
    err_d      = err_q;
    cfg_we_o   = 1'b0;
    cfg_word_o = '0;
    cnt_re_o   = 1'b0;
    div_start  = 1'b0;
    div_num    = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          src_d   = src_i;
          gate_d  = GATE_W'(GATE_MAX);
          state_d = ST_CLR;
        end
      end
      ST_CLR: begin
        cfg_we_o = 1'b1;
        state_d  = ST_PROG;
      end
      ST_PROG: begin
        cfg_we_o   = 1'b1;
        cfg_word_o = prog_word;
        state_d    = ST_ARM;
      end
      ST_ARM: begin
        cfg_we_o            = 1'b1;
        cfg_word_o          = prog_word;
        cfg_word_o[EN_BIT]  = 1'b1;
        cfg_word_o[RUN_BIT] = 1'b1;
        state_d             = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_tick) begin
          if (!meas_busy_i) begin
            state_d = ST_DIS;
          end else if (tmr_last) begin
            err_d   = ERR_TIMEOUT;
            freq_d  = '0;
            prec_d  = '0;
            state_d = ST_FIN;
          end
        end
      end
      ST_DIS: begin
        cfg_we_o            = 1'b1;
        cfg_word_o          = prog_word;
        cfg_word_o[RUN_BIT] = 1'b1;
        state_d             = ST_READ;
      end
      ST_READ: begin
        cnt_re_o = 1'b1;
        cnt_d    = cnt_val_i;
        state_d  = ST_EVAL;
      end
      ST_EVAL: begin
        if (cnt_q == CNT_SAT) begin
          if (gate_q <= GATE_W'(GATE_MIN)) begin
            err_d   = ERR_OVERFLOW;
            freq_d  = '0;
            prec_d  = '0;
            state_d = ST_FIN;
          end else begin
            gate_d  = gate_q - GATE_W'(GATE_STEP);
            state_d = ST_CLR;
          end
        end else begin
          div_start = 1'b1;
          div_num   = NUM_W'(cnt_q) * NUM_W'(SCALE) + NUM_W'(gate_q >> 1);
          state_d   = ST_DIVF;
        end
      end
      ST_DIVF: begin
        if (div_done) begin
          freq_d    = div_res;
          div_start = 1'b1;
          div_num   = NUM_W'(PREC_NUM);
          state_d   = ST_DIVP;
        end
      end
      ST_DIVP: begin
        if (div_done) begin
          prec_d  = div_res;
          err_d   = ERR_NONE;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      gate_q  <= '0;
      cnt_q   <= '0;
      freq_q  <= '0;
      prec_q  <= '0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      gate_q  <= gate_d;
      cnt_q   <= cnt_d;
      freq_q  <= freq_d;
      prec_q  <= prec_d;
      err_q   <= err_d;
    end
  end

  assign done_o = (state_q == ST_FIN);
  assign err_o  = err_q;
  assign freq_o = freq_q;
  assign prec_o = prec_q;
endmodule

// File: rtl/fms_autorange_chk.sv
`timescale 1ns/1ps
module fms_autorange_chk #(
  parameter int GDIV_W    = 16,
  parameter int OUT_W     = 32,
  parameter int CFG_W     = 32,
  parameter int GATE_MAX  = 640,
  parameter int GATE_STEP = 32,
  parameter int GATE_MIN  = 32,
  parameter int PREC_NUM  = 2000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_o,
  input logic [1:0]       err_o,
  input logic [OUT_W-1:0] freq_o,
  input logic [OUT_W-1:0] prec_o,
  input logic             cfg_we_o,
  input logic [CFG_W-1:0] cfg_word_o,
  input logic             cnt_re_o
);
  localparam int EN_BIT  = GDIV_W;
  localparam int RUN_BIT = GDIV_W + 1;

  logic       is_arm;
  logic       is_prog;
  int unsigned gate_f;
  assign is_arm  = cfg_we_o && cfg_word_o[EN_BIT];
  assign is_prog = cfg_we_o && !cfg_word_o[EN_BIT] && !cfg_word_o[RUN_BIT] && (cfg_word_o != '0);
  assign gate_f  = 32'(cfg_word_o[GDIV_W-1:0]) + 32'd1;

  // R8
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4 and R7: error results carry zero values
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o != 2'b00) |-> (freq_o == '0 && prec_o == '0));

  a_r1_gate_legal: assert property (@(posedge clk) disable iff (!rst_n)
    is_arm |-> ((gate_f % GATE_STEP) == 0 && gate_f <= GATE_MAX && gate_f >= GATE_MIN));

  a_r3_arm_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
    is_arm |-> ($past(cfg_we_o) && !$past(cfg_word_o[EN_BIT]) &&
                $past(cfg_word_o[GDIV_W-1:0]) == cfg_word_o[GDIV_W-1:0]));

  a_r3_clear_before_prog: assert property (@(posedge clk) disable iff (!rst_n)
    is_prog |-> ($past(cfg_we_o) && $past(cfg_word_o) == '0));

  a_r3_read_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_re_o |-> ($past(cfg_we_o) && $past(cfg_word_o[RUN_BIT]) && !$past(cfg_word_o[EN_BIT])));

  a_r6_prec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'b00) |-> (prec_o >= OUT_W'(PREC_NUM / GATE_MAX) &&
                                    prec_o <= OUT_W'(PREC_NUM / GATE_MIN)));
endmodule

bind fms_autorange fms_autorange_chk #(
  .GDIV_W(GDIV_W), .OUT_W(OUT_W), .CFG_W(CFG_W), .GATE_MAX(GATE_MAX),
  .GATE_STEP(GATE_STEP), .GATE_MIN(GATE_MIN), .PREC_NUM(PREC_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .err_o(err_o), .freq_o(freq_o),
  .prec_o(prec_o), .cfg_we_o(cfg_we_o), .cfg_word_o(cfg_word_o), .cnt_re_o(cnt_re_o)
);

// File: tb/tb_fms_autorange.sv
`timescale 1ns/1ps
module tb_fms_autorange;
  localparam int CPU  = 1;
  localparam int PUS  = 10;
  localparam int TOUS = 1000;
  localparam int P    = PUS * CPU;
  localparam int NP   = TOUS / PUS;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [6:0] src_in;
  logic done;
  logic [1:0] err;
  logic [31:0] freq, prec, cfg_word;
  logic cfg_we, cnt_re, busy_m;
  logic [15:0] cnt_m;

  always #2.5 clk = ~clk;

  fms_autorange #(.CLKS_PER_US(CPU), .POLL_US(PUS), .TIMEOUT_US(TOUS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src_in), .done_o(done),
    .err_o(err), .freq_o(freq), .prec_o(prec), .cfg_we_o(cfg_we),
    .cfg_word_o(cfg_word), .meas_busy_i(busy_m), .cnt_re_o(cnt_re), .cnt_val_i(cnt_m)
  );

  int n_tests = 0;
  int n_fail  = 0;
  longint cyc = 0;
  longint cur_f = 0;
  bit stuck = 0;

  // monitor state per request
  int phase, exp_g, attempts, seq_bad, poll_bad, done_seen;
  logic [6:0] exp_src;
  longint arm_cyc, done_cyc;
  logic [31:0] got_freq, got_prec;
  logic [1:0]  got_err;

  function automatic logic [15:0] sat_count(longint f, int g);
    longint c = (f * g) / 1000000;
    return (c >= 65535) ? 16'hFFFF : 16'(c);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // counter model: busy for gate*CPU cycles after an arming write
  int left_m, gate_m;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0; left_m <= 0; gate_m <= 0; cnt_m <= 16'h0;
    end else if (cfg_we && cfg_word[16] && cfg_word[17]) begin
      busy_m <= 1'b1;
      left_m <= (int'(cfg_word[15:0]) + 1) * CPU;
      gate_m <= int'(cfg_word[15:0]) + 1;
    end else if (busy_m && !stuck) begin
      if (left_m <= 1) begin
        busy_m <= 1'b0;
        cnt_m  <= sat_count(cur_f, gate_m);
      end else begin
        left_m <= left_m - 1;
      end
    end
  end

  // write-sequence monitor (R3, R1, R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_we) begin
        case (phase)
          0: if (cfg_word != 32'h0) seq_bad++;
          1: if (cfg_word[31:25] != 0 || cfg_word[17:16] != 2'b00 || cfg_word[24:18] != exp_src ||
                 int'(cfg_word[15:0]) + 1 != exp_g) seq_bad++;
          2: begin
               if (cfg_word[31:25] != 0 || cfg_word[17:16] != 2'b11 || cfg_word[24:18] != exp_src ||
                   int'(cfg_word[15:0]) + 1 != exp_g) seq_bad++;
               arm_cyc = cyc;
               attempts++;
             end
          default: begin
               if (cfg_word[31:25] != 0 || cfg_word[17:16] != 2'b10 || cfg_word[24:18] != exp_src ||
                   int'(cfg_word[15:0]) + 1 != exp_g) seq_bad++;
               if (cyc - arm_cyc != longint'(((exp_g * CPU) / P + 1) * P + 1)) poll_bad++;
             end
        endcase
        if (phase == 3) begin
          phase = 0;
          exp_g = exp_g - 32;
        end else begin
          phase = phase + 1;
        end
      end
      if (done) begin
        done_seen++;
        done_cyc = cyc;
        got_freq = freq;
        got_prec = prec;
        got_err  = err;
      end
    end
  end

  task automatic run_req(input longint f, input bit stk, input logic [6:0] src, input bit inject);
    longint e_freq = 0, e_prec = 0;
    int e_err = 2, e_att = 0, waited = 0;
    string etag;
    if (stk) begin
      e_att = 1; e_err = 1;
    end else begin
      for (int g = 640; g >= 32; g -= 32) begin
        logic [15:0] c = sat_count(f, g);
        e_att++;
        if (c != 16'hFFFF) begin
          e_freq = (longint'(c) * 1000000 + g / 2) / g;
          e_prec = 2000000 / g;
          e_err  = 0;
          break;
        end
      end
    end
    etag = (e_err == 1) ? "R4 timeout code" : ((e_err == 2) ? "R7 overflow code" : "R2 no-error code");
    phase = 0; exp_g = 640; exp_src = src; attempts = 0; seq_bad = 0; poll_bad = 0; done_seen = 0;
    cur_f = f; stuck = stk;
    @(negedge clk); start = 1'b1; src_in = src;
    @(negedge clk); start = 1'b0; src_in = 7'($urandom);
    while (done_seen == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (inject && waited == 40) begin start = 1'b1; src_in = src ^ 7'h55; end
      else if (inject && waited == 41) start = 1'b0;
    end
    check(done_seen == 1, "R8 done seen", done_seen, 1);
    check(got_err == 2'(e_err), etag, got_err, e_err);
    check(got_freq == 32'(e_freq), (e_err == 0) ? "R5 freq" : "R7 freq zero", got_freq, e_freq);
    check(got_prec == 32'(e_prec), (e_err == 0) ? "R6 prec" : "R7 prec zero", got_prec, e_prec);
    check(attempts == e_att, "R1 attempt count", attempts, e_att);
    check(seq_bad == 0, inject ? "R9 source kept / R3 sequence" : "R3 write sequence", seq_bad, 0);
    if (stk) check(done_cyc - arm_cyc == longint'(NP * P + 1), "R4 timeout cycle", done_cyc - arm_cyc, NP * P + 1);
    else     check(poll_bad == 0, "R4 poll timing", poll_bad, 0);
    @(negedge clk);
    check(done == 1'b0 && freq == got_freq && prec == got_prec && err == got_err,
          "R8 pulse and hold", done, 0);
    if (inject) begin
      repeat (100) @(negedge clk);
      check(done_seen == 1, "R9 no extra done", done_seen, 1);
    end
    stuck = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    rst_n = 1'b0; start = 1'b0; src_in = 7'h0;
    phase = 0; exp_g = 640; exp_src = 0; attempts = 0; seq_bad = 0; poll_bad = 0; done_seen = 0;
    arm_cyc = 0; done_cyc = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 0 && err == 0, "R10 reset done/err", {done, err}, 0);
    check(freq == 0 && prec == 0, "R10 reset results", freq | prec, 0);
    check(cfg_we == 0 && cnt_re == 0, "R10 reset strobes", {cfg_we, cnt_re}, 0);

    run_req(64'd0,          0, 7'd3,  0);   // zero count
    run_req(64'd102398000,  0, 7'd81, 0);   // just fits at 640
    run_req(64'd102400000,  0, 7'd7,  0);   // first overflow, R2 retry
    run_req(64'd2047000000, 0, 7'd127, 0);  // accepted only at the 32 gate
    run_req(64'd2100000000, 0, 7'd12, 0);   // R7 all gates overflow
    run_req(64'd50000000,   1, 7'd20, 0);   // R4 busy stuck
    run_req(64'd24000000,   0, 7'd44, 1);   // R9 start while active

    for (int i = 0; i < 14; i++) begin
      int unsigned r = $urandom % 3;
      longint f;
      if (r == 0)      f = longint'($urandom % 100000000);
      else if (r == 1) f = 64'd100000000 + longint'($urandom % 1900000000);
      else             f = 64'd2000000000 + longint'($urandom % 100000000);
      run_req(f, 0, 7'($urandom), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule